// File: doc/BRIEF.md
# Buck-Boost Mode Selector with Dual PWM

This block is the digital control core for a two-switch non-inverting buck-boost power stage. Each time a strobe delivers an input-voltage code and an output-voltage code, it compares the input code with a setpoint code and picks one of three switch patterns: step-down, step-up, or both switches modulated. It then works out a duty for each switch from the ratio of the two voltage samples. The two divisions share one multi-cycle restoring divider.

Both gate signals come from one free-running counter. Each gate rises at the start of every period and falls once the counter reaches that gate's duty. A newly computed duty pair and its mode are held in a staging buffer. They become active only when the counter wraps, so a period is never cut short or stretched halfway through. The active mode is reported as a 2-bit code. A valid flag shows that a computed pair has reached the outputs.

Top module: `bb_mode_pwm`

## Requirements
- R1: After reset both gates are low, the mode code is 11 (idle) and valid is low. They stay that way until the first sample strobe has been processed.
- R2: The mode code is chosen from the sample's input code against the setpoint code: input greater gives 00 (step-down), input smaller gives 01 (step-up), equal gives 10 (both modulated).
- R3: In mode 00 the step-down duty is floor(vout*255/vin), saturated to 255 when vout >= vin. The step-up gate stays low for the whole period.
- R4: In mode 01 the step-down gate is continuously high. The step-up duty is 255 - floor(vin*255/vout), and it is 0 when vin >= vout.
- R5: In mode 10 both gates are modulated, using the step-down duty of R3 and the step-up duty of R4.
- R6: A zero divisor forces that duty to 0. vin = 0 gives a step-down duty of 0, except in mode 01 where R4 holds that gate high. vout = 0 gives a step-up duty of 0.
- R7: The PWM period is 256 clock cycles. Each gate rises at the period start and is high for exactly d cycles of the period, where d is its duty. A duty of 255 keeps the gate high for all 256 cycles. Both gates start their high time in the same cycle.
- R8: New duties and a new mode code take effect only at the first cycle of a period. Mode and duties never change in the middle of a period.
- R9: Valid rises together with the first applied duty pair and then stays high. While valid is low the mode code is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld_i | input | 1 | One-cycle strobe: a sample pair is present |
| vin_i | input | 8 | Input-voltage sample code |
| vout_i | input | 8 | Output-voltage sample code |
| setpt_i | input | 8 | Setpoint code |
| gate_buck_o | output | 1 | Step-down switch gate |
| gate_boost_o | output | 1 | Step-up switch gate |
| mode_o | output | 2 | Active mode: 00 step-down, 01 step-up, 10 both, 11 idle |
| valid_o | output | 1 | A computed duty pair is active |

## Verification
Several properties are checked on every cycle:
- the divider's result satisfies quotient times divisor plus remainder equals the dividend;
- the active duties and mode hold still except at the period start;
- a gate only rises at counter zero and only falls when the counter equals its duty;
- the idle code is present while valid is low.

The duty values themselves, the mode decision and the zero-divisor cases can only be shown by the bench. It sweeps combinations of input, output and setpoint codes and counts the high cycles of each gate over a full period. It also checks that every mode change falls on a period boundary.

// File: rtl/bbc_pkg.sv
package bbc_pkg;

    typedef enum logic [1:0] {
        MODE_BUCK  = 2'b00,
        MODE_BOOST = 2'b01,
        MODE_BB    = 2'b10,
        MODE_IDLE  = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        PL_IDLE,
        PL_BK,
        PL_BK_WAIT,
        PL_BS,
        PL_BS_WAIT,
        PL_LOAD
    } plan_st_e;

endpackage

// File: rtl/rdiv_unit.sv
module rdiv_unit #(
    parameter int NW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [NW-1:0] num_i,
    input  logic [DW-1:0] den_i,
    output logic          done_o,
    output logic [NW-1:0] quo_o
);
    localparam int CW = $clog2(NW) + 1;
    localparam int PW = NW + DW + 1;

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [NW-1:0] quo;
        logic [DW:0]   rem;
        logic [DW-1:0] den;
        logic [NW-1:0] num;
    } div_t;

    div_t d_d, d_q;
    logic [DW:0]   shifted;
    logic [DW+1:0] trial;

    always_comb begin
        d_d      = d_q;
        d_d.done = 1'b0;
        shifted  = {d_q.rem[DW-1:0], d_q.quo[NW-1]};
        trial    = {1'b0, shifted} - {2'b00, d_q.den};
        if (start_i && !d_q.busy) begin
            d_d.busy = 1'b1;
            d_d.cnt  = '0;
            d_d.quo  = num_i;
            d_d.rem  = '0;
            d_d.den  = den_i;
            d_d.num  = num_i;
        end else if (d_q.busy) begin
            if (!trial[DW+1]) begin
                d_d.rem = trial[DW:0];
                d_d.quo = {d_q.quo[NW-2:0], 1'b1};
            end else begin
                d_d.rem = shifted;
                d_d.quo = {d_q.quo[NW-2:0], 1'b0};
            end
            d_d.cnt = d_q.cnt + 1'b1;
            if (d_q.cnt == CW'(NW - 1)) begin
                d_d.busy = 1'b0;
                d_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign done_o = d_q.done;
    assign quo_o  = d_q.quo;

    // R3
    div_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_q.done |-> (PW'(d_q.quo) * PW'(d_q.den) + PW'(d_q.rem) == PW'(d_q.num)));

endmodule

// File: rtl/duty_planner.sv
module duty_planner
    import bbc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           smp_vld_i,
    input  logic [W-1:0]   vin_i,
    input  logic [W-1:0]   vout_i,
    input  logic [W-1:0]   setpt_i,
    input  logic           div_done_i,
    input  logic [2*W-1:0] div_quo_i,
    output logic           div_start_o,
    output logic [2*W-1:0] div_num_o,
    output logic [W-1:0]   div_den_o,
    output logic           upd_o,
    output mode_e          mode_o,
    output logic [W-1:0]   buck_duty_o,
    output logic [W-1:0]   boost_duty_o
);
    localparam int          NW   = 2 * W;
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    typedef struct packed {
        plan_st_e       st;
        logic [W-1:0]   vin;
        logic [W-1:0]   vout;
        mode_e          mode;
        logic [W-1:0]   bk;
        logic [W-1:0]   bs;
        logic           upd;
        logic           start;
        logic [NW-1:0]  num;
        logic [W-1:0]   den;
    } plan_t;

    plan_t p_d, p_q;
    logic [W-1:0] quo_sat;

    assign quo_sat = (|div_quo_i[NW-1:W]) ? MAXV : div_quo_i[W-1:0];

    always_comb begin
        p_d       = p_q;
        p_d.upd   = 1'b0;
        p_d.start = 1'b0;
        case (p_q.st)
            PL_IDLE: begin
                if (smp_vld_i) begin
                    p_d.vin  = vin_i;
                    p_d.vout = vout_i;
                    if (vin_i > setpt_i)      p_d.mode = MODE_BUCK;
                    else if (vin_i < setpt_i) p_d.mode = MODE_BOOST;
                    else                      p_d.mode = MODE_BB;
                    p_d.st = PL_BK;
                end
            end
            PL_BK: begin
                if (p_q.vin == '0) begin
                    p_d.bk = '0;
                    p_d.st = PL_BS;
                end else if (p_q.vout >= p_q.vin) begin
                    p_d.bk = MAXV;
                    p_d.st = PL_BS;
                end else begin
                    p_d.num   = NW'(p_q.vout) * NW'(MAXV);
                    p_d.den   = p_q.vin;
                    p_d.start = 1'b1;
                    p_d.st    = PL_BK_WAIT;
                end
            end
            PL_BK_WAIT: begin
                if (div_done_i) begin
                    p_d.bk = quo_sat;
                    p_d.st = PL_BS;
                end
            end
            PL_BS: begin
                if (p_q.vout == '0 || p_q.vin >= p_q.vout) begin
                    p_d.bs = '0;
                    p_d.st = PL_LOAD;
                end else begin
                    p_d.num   = NW'(p_q.vin) * NW'(MAXV);
                    p_d.den   = p_q.vout;
                    p_d.start = 1'b1;
                    p_d.st    = PL_BS_WAIT;
                end
            end
            PL_BS_WAIT: begin
                if (div_done_i) begin
                    p_d.bs = MAXV - quo_sat;
                    p_d.st = PL_LOAD;
                end
            end
            PL_LOAD: begin
                if (p_q.mode == MODE_BUCK)  p_d.bs = '0;
                if (p_q.mode == MODE_BOOST) p_d.bk = MAXV;
                p_d.upd = 1'b1;
                p_d.st  = PL_IDLE;
            end
            default: p_d.st = PL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q      <= '0;
            p_q.st   <= PL_IDLE;
            p_q.mode <= MODE_IDLE;
        end else begin
            p_q <= p_d;
        end
    end

    assign div_start_o  = p_q.start;
    assign div_num_o    = p_q.num;
    assign div_den_o    = p_q.den;
    assign upd_o        = p_q.upd;
    assign mode_o       = p_q.mode;
    assign buck_duty_o  = p_q.bk;
    assign boost_duty_o = p_q.bs;

    // R6
    zero_vin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.upd && p_q.vin == '0 && p_q.mode != MODE_BOOST) |-> (p_q.bk == '0));

    // R6
    zero_vout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.upd && p_q.vout == '0) |-> (p_q.bs == '0));

endmodule

// File: rtl/pwm_dual.sv
module pwm_dual
    import bbc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd_i,
    input  mode_e        mode_i,
    input  logic [W-1:0] buck_i,
    input  logic [W-1:0] boost_i,
    output logic         gate_buck_o,
    output logic         gate_boost_o,
    output mode_e        mode_o,
    output logic         valid_o
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         pend;
        logic [W-1:0] pbk;
        logic [W-1:0] pbs;
        mode_e        pmode;
        logic [W-1:0] abk;
        logic [W-1:0] abs_;
        mode_e        amode;
        logic         valid;
    } pwm_t;

    pwm_t w_d, w_q;
    logic wrap;

    always_comb begin
        w_d     = w_q;
        wrap    = (w_q.cnt == MAXV);
        w_d.cnt = w_q.cnt + 1'b1;
        if (upd_i) begin
            w_d.pend  = 1'b1;
            w_d.pbk   = buck_i;
            w_d.pbs   = boost_i;
            w_d.pmode = mode_i;
        end
        if (wrap && (upd_i || w_q.pend)) begin
            w_d.abk   = upd_i ? buck_i  : w_q.pbk;
            w_d.abs_  = upd_i ? boost_i : w_q.pbs;
            w_d.amode = upd_i ? mode_i  : w_q.pmode;
            w_d.valid = 1'b1;
            w_d.pend  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q       <= '0;
            w_q.pmode <= MODE_IDLE;
            w_q.amode <= MODE_IDLE;
        end else begin
            w_q <= w_d;
        end
    end

    assign gate_buck_o  = (w_q.abk  == MAXV) || (w_q.cnt < w_q.abk);
    assign gate_boost_o = (w_q.abs_ == MAXV) || (w_q.cnt < w_q.abs_);
    assign mode_o       = w_q.amode;
    assign valid_o      = w_q.valid;

    // R8
    mid_period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.cnt != '0) |-> ($stable(w_q.abk) && $stable(w_q.abs_) && $stable(w_q.amode)));

    // R7
    rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_buck_o) || $rose(gate_boost_o)) |-> (w_q.cnt == '0));

    // R7
    fall_at_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_buck_o) |-> (w_q.cnt == w_q.abk));

    // R9
    idle_until_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !w_q.valid |-> (w_q.amode == MODE_IDLE && !gate_buck_o && !gate_boost_o));

    // R9
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.valid |=> w_q.valid);

endmodule

// File: rtl/bb_mode_pwm.sv
module bb_mode_pwm
    import bbc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_vld_i,
    input  logic [W-1:0] vin_i,
    input  logic [W-1:0] vout_i,
    input  logic [W-1:0] setpt_i,
    output logic         gate_buck_o,
    output logic         gate_boost_o,
    output logic [1:0]   mode_o,
    output logic         valid_o
);
    localparam int NW = 2 * W;

    logic          div_start, div_done, upd;
    logic [NW-1:0] div_num, div_quo;
    logic [W-1:0]  div_den, buck_duty, boost_duty;
    mode_e         plan_mode, act_mode;

    duty_planner #(.W(W)) i_planner (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_vld_i    (smp_vld_i),
        .vin_i        (vin_i),
        .vout_i       (vout_i),
        .setpt_i      (setpt_i),
        .div_done_i   (div_done),
        .div_quo_i    (div_quo),
        .div_start_o  (div_start),
        .div_num_o    (div_num),
        .div_den_o    (div_den),
        .upd_o        (upd),
        .mode_o       (plan_mode),
        .buck_duty_o  (buck_duty),
        .boost_duty_o (boost_duty)
    );

    rdiv_unit #(.NW(NW), .DW(W)) i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_start),
        .num_i   (div_num),
        .den_i   (div_den),
        .done_o  (div_done),
        .quo_o   (div_quo)
    );

    pwm_dual #(.W(W)) i_pwm (
        .clk          (clk),
        .rst_n        (rst_n),
        .upd_i        (upd),
        .mode_i       (plan_mode),
        .buck_i       (buck_duty),
        .boost_i      (boost_duty),
        .gate_buck_o  (gate_buck_o),
        .gate_boost_o (gate_boost_o),
        .mode_o       (act_mode),
        .valid_o      (valid_o)
    );

    assign mode_o = act_mode;

endmodule

// File: tb/test_bb_mode_pwm.sv
module test_bb_mode_pwm;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_vld_i = 1'b0;
    logic [7:0] vin_i = '0, vout_i = '0, setpt_i = '0;
    logic       gate_buck_o, gate_boost_o, valid_o;
    logic [1:0] mode_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int phase = 0;
    bit phase_ok = 1'b0;
    logic       prev_bk = 1'b0, prev_bs = 1'b0;
    logic [1:0] prev_mode = 2'b11;

    always #10 clk = ~clk;

    bb_mode_pwm i_bb_mode_pwm (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_vld_i    (smp_vld_i),
        .vin_i        (vin_i),
        .vout_i       (vout_i),
        .setpt_i      (setpt_i),
        .gate_buck_o  (gate_buck_o),
        .gate_boost_o (gate_boost_o),
        .mode_o       (mode_o),
        .valid_o      (valid_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_mode(input int vi, input int sp);
        if (vi > sp) return 0;
        if (vi < sp) return 1;
        return 2;
    endfunction

    function automatic int ratio_bk(input int vi, input int vo);
        if (vi == 0) return 0;
        if (vo >= vi) return 255;
        return (vo * 255) / vi;
    endfunction

    function automatic int ratio_bs(input int vi, input int vo);
        if (vo == 0) return 0;
        if (vi >= vo) return 0;
        return 255 - (vi * 255) / vo;
    endfunction

    // Period-alignment monitor: rises and mode changes must fall on period starts (R7, R8)
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (gate_buck_o && !prev_bk) begin
                if (!phase_ok) begin
                    phase    = cyc % 256;
                    phase_ok = 1'b1;
                end else check("R7 step-down rise phase", cyc % 256, phase);
            end
            if (gate_boost_o && !prev_bs && phase_ok)
                check("R7 step-up rise phase", cyc % 256, phase);
            if (mode_o != prev_mode && phase_ok)
                check("R8 mode change phase", cyc % 256, phase);
            prev_bk   = gate_buck_o;
            prev_bs   = gate_boost_o;
            prev_mode = mode_o;
        end
    end

    task automatic run_case(input int vi, input int vo, input int sp);
        int m, ebk, ebs, nbk, nbs;
        string rq;
        @(negedge clk);
        vin_i = 8'(vi); vout_i = 8'(vo); setpt_i = 8'(sp);
        smp_vld_i = 1'b1;
        @(negedge clk);
        smp_vld_i = 1'b0;
        repeat (400) @(negedge clk);
        m   = exp_mode(vi, sp);
        ebk = (m == 1) ? 255 : ratio_bk(vi, vo);
        ebs = (m == 0) ? 0   : ratio_bs(vi, vo);
        nbk = 0; nbs = 0;
        for (int k = 0; k < 256; k++) begin
            if (gate_buck_o)  nbk++;
            if (gate_boost_o) nbs++;
            @(negedge clk);
        end
        check("R2 mode code", int'(mode_o), m);
        check("R9 valid high", int'(valid_o), 1);
        rq = (m == 0) ? "R3" : (m == 1) ? "R4" : "R5";
        if (vi == 0 || vo == 0) rq = {rq, "/R6"};
        check({rq, "/R7 step-down high cycles"}, nbk, (ebk == 255) ? 256 : ebk);
        check({rq, "/R7 step-up high cycles"},   nbs, (ebs == 255) ? 256 : ebs);
    endtask

    initial begin
        int vl[4] = '{3, 60, 130, 255};
        int ol[3] = '{5, 77, 200};
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, held with no strobe
        check("R1 mode idle", int'(mode_o), 3);
        check("R1 valid low", int'(valid_o), 0);
        hi = 0;
        for (int k = 0; k < 300; k++) begin
            if (gate_buck_o || gate_boost_o) hi++;
            @(negedge clk);
        end
        check("R1 gates low before first sample", hi, 0);
        check("R9 idle before first sample", int'(mode_o), 3);

        run_case(200, 100, 150);   // R3
        run_case(100, 200, 150);   // R4
        run_case(150, 150, 150);   // R5
        run_case(120, 90, 120);    // R5
        run_case(90, 120, 90);     // R5
        run_case(0, 50, 10);       // R4 R6
        run_case(0, 50, 0);        // R5 R6
        run_case(50, 0, 10);       // R3 R6
        run_case(50, 0, 50);       // R5 R6
        run_case(255, 1, 0);       // R3
        run_case(1, 255, 2);       // R4
        run_case(255, 255, 255);   // R5 saturation

        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 3; b++)
                for (int s = 0; s < 3; s++)
                    if (vl[a] + s - 1 <= 255)
                        run_case(vl[a], ol[b], vl[a] + s - 1);

        check("R7 period phase captured", int'(phase_ok), 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule